// File: doc/BRIEF.md
# Capture-to-DMA Request Bridge

The bridge sits between a complementary pair of input-capture channels and a single DMA channel. Each capture channel reports rising-edge and falling-edge capture strobes, and each strobe comes with a 16-bit counter value. A channel-select input picks the one channel of the pair that is served. A 2-bit mode input chooses which edge types are forwarded. An order input decides which edge wins when a rising and a falling strobe land in the same cycle.

An accepted value is copied into one shared transfer buffer, and a DMA request is raised. The request stays up until the DMA controller returns a one-cycle acknowledge, which tells the bridge the buffer has been read and written to memory. Captures that arrive while a transfer is still outstanding are thrown away and recorded in a sticky overrun flag. A channel-enable input gates the whole bridge.

Top module: `cap_dma_bridge`

## Requirements
- R1: After reset `dma_req_o` is 0, `buf_o` is 0 and `overrun_o` is 0.
- R2: `chan_sel_i` = 0 serves channel 0 (bits [15:0] of each packed input and bit 0 of each strobe vector). `chan_sel_i` = 1 serves channel 1 (bits [31:16] and bit 1). Strobes of the channel that is not selected have no effect.
- R3: `mode_i` encodes the filter as follows. 0 forwards nothing. 1 forwards rising-edge captures only. 2 forwards falling-edge captures only. 3 forwards both. Bit 0 enables rising and bit 1 enables falling.
- R4: In mode 3, a rising and a falling strobe in the same cycle load only one value. With `order_i` = 1 the rising value is loaded and the falling value is discarded. With `order_i` = 0 the falling value is loaded.
- R5: An accepted capture taken while the bridge is idle and enabled appears on `buf_o`, with `dma_req_o` = 1, one clock after the strobe cycle.
- R6: While `dma_req_o` is 1, it stays 1 and `buf_o` stays unchanged until an acknowledge is sampled.
- R7: A forwarded capture that arrives while a request is pending is dropped. This includes a capture in the same cycle as the acknowledge. A dropped capture sets `overrun_o`, which stays 1 until reset.
- R8: `dma_req_o` falls one clock after `dma_ack_i` is sampled high. The next forwarded capture raises it again. An acknowledge while no request is pending has no effect.
- R9: While `en_i` is low, `dma_req_o` is 0 from the next clock on, `buf_o` holds its value, and captures are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Bridge enable |
| chan_sel_i | input | 1 | Channel of the pair to serve |
| mode_i | input | 2 | Edge filter mode |
| order_i | input | 1 | Same-cycle edge priority (1 = rising) |
| rise_evt_i | input | 2 | Rising capture strobes, one per channel |
| fall_evt_i | input | 2 | Falling capture strobes, one per channel |
| rise_val_i | input | 32 | Rising capture values, packed per channel |
| fall_val_i | input | 32 | Falling capture values, packed per channel |
| dma_ack_i | input | 1 | DMA acknowledge pulse |
| dma_req_o | output | 1 | DMA request |
| buf_o | output | 16 | Transfer buffer contents |
| overrun_o | output | 1 | Sticky dropped-capture flag |

## Verification
All state in the bridge can be seen at the ports. A request bit that is stuck or left behind shows up within one clock as a wrong `dma_req_o` after an acknowledge or after a disable. A wrong channel choice or a wrong edge priority shows up in `buf_o` on the clock that follows the strobe. A missed overrun, or a buffer overwritten while a request is pending, shows up in `overrun_o` or `buf_o` one clock after the dropped capture. For this reason the behavioural model is compared with every output on every cycle.

// File: rtl/cap_dma_pkg.sv
package cap_dma_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RISE = 2'd1,
    MODE_FALL = 2'd2,
    MODE_BOTH = 2'd3
  } cap_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_hit_t;

endpackage

// File: rtl/cap_chan_mux.sv
module cap_chan_mux
  import cap_dma_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int DATA_W = 16,
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [N_CH-1:0]        rise_evt_i,
  input  logic [N_CH-1:0]        fall_evt_i,
  input  logic [N_CH*DATA_W-1:0] rise_val_i,
  input  logic [N_CH*DATA_W-1:0] fall_val_i,
  output edge_hit_t              evt_o,
  output logic [DATA_W-1:0]      rise_val_o,
  output logic [DATA_W-1:0]      fall_val_o
);

  logic [N_CH-1:0] ch_hot;

  for (genvar k = 0; k < N_CH; k++) begin : g_dec
    assign ch_hot[k] = (sel_i == SEL_W'(k));
  end

  always_comb begin
    evt_o      = '0;
    rise_val_o = '0;
    fall_val_o = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (ch_hot[k]) begin
        evt_o.rise = rise_evt_i[k];
        evt_o.fall = fall_evt_i[k];
        rise_val_o = rise_val_i[k*DATA_W +: DATA_W];
        fall_val_o = fall_val_i[k*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/cap_edge_pick.sv
module cap_edge_pick
  import cap_dma_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  cap_mode_e          mode_i,
  input  logic               order_i,
  input  edge_hit_t          evt_i,
  input  logic [DATA_W-1:0]  rise_val_i,
  input  logic [DATA_W-1:0]  fall_val_i,
  output logic               hit_o,
  output logic [DATA_W-1:0]  val_o
);

  logic want_rise, want_fall;
  logic take_rise, take_fall;

  assign want_rise = (mode_i == MODE_RISE) || (mode_i == MODE_BOTH);
  assign want_fall = (mode_i == MODE_FALL) || (mode_i == MODE_BOTH);

  // same-cycle clash: order_i picks the winner, loser is discarded
  assign take_rise = want_rise && evt_i.rise && (!(want_fall && evt_i.fall) || order_i);
  assign take_fall = want_fall && evt_i.fall && !take_rise;

  assign hit_o = take_rise || take_fall;
  assign val_o = take_rise ? rise_val_i : fall_val_i;

endmodule

// File: rtl/cap_xfer_buf.sv
module cap_xfer_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              ovr_o
);

  logic              req_q;
  logic [DATA_W-1:0] buf_q;
  logic              ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      buf_q <= '0;
      ovr_q <= 1'b0;
    end else if (!en_i) begin
      req_q <= 1'b0;
    end else if (req_q) begin
      if (hit_i) ovr_q <= 1'b1;
      if (ack_i) req_q <= 1'b0;
    end else if (hit_i) begin
      buf_q <= val_i;
      req_q <= 1'b1;
    end
  end

  assign req_o = req_q;
  assign buf_o = buf_q;
  assign ovr_o = ovr_q;

endmodule

// File: rtl/cap_dma_bridge.sv
module cap_dma_bridge
  import cap_dma_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int DATA_W = 16,
  localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic [SEL_W-1:0]       chan_sel_i,
  input  logic [1:0]             mode_i,
  input  logic                   order_i,
  input  logic [N_CH-1:0]        rise_evt_i,
  input  logic [N_CH-1:0]        fall_evt_i,
  input  logic [N_CH*DATA_W-1:0] rise_val_i,
  input  logic [N_CH*DATA_W-1:0] fall_val_i,
  input  logic                   dma_ack_i,
  output logic                   dma_req_o,
  output logic [DATA_W-1:0]      buf_o,
  output logic                   overrun_o
);

  edge_hit_t         sel_evt;
  logic [DATA_W-1:0] sel_rval, sel_fval;
  logic              hit;
  logic [DATA_W-1:0] hit_val;

  cap_chan_mux #(.N_CH(N_CH), .DATA_W(DATA_W)) u_mux (
    .sel_i      (chan_sel_i),
    .rise_evt_i (rise_evt_i),
    .fall_evt_i (fall_evt_i),
    .rise_val_i (rise_val_i),
    .fall_val_i (fall_val_i),
    .evt_o      (sel_evt),
    .rise_val_o (sel_rval),
    .fall_val_o (sel_fval)
  );

  cap_edge_pick #(.DATA_W(DATA_W)) u_pick (
    .mode_i     (cap_mode_e'(mode_i)),
    .order_i    (order_i),
    .evt_i      (sel_evt),
    .rise_val_i (sel_rval),
    .fall_val_i (sel_fval),
    .hit_o      (hit),
    .val_o      (hit_val)
  );

  cap_xfer_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .hit_i  (hit),
    .val_i  (hit_val),
    .ack_i  (dma_ack_i),
    .req_o  (dma_req_o),
    .buf_o  (buf_o),
    .ovr_o  (overrun_o)
  );

endmodule

// File: rtl/cap_dma_bridge_chk.sv
module cap_dma_bridge_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [1:0]        mode_i,
  input logic              dma_ack_i,
  input logic              dma_req_o,
  input logic [DATA_W-1:0] buf_o,
  input logic              overrun_o
);

  // R9
  assert_dis_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !dma_req_o);

  // R8
  assert_ack_drops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && dma_ack_i) |=> !dma_req_o);

  // R6
  assert_buf_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> $stable(buf_o));

  // R6
  assert_req_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_req_o && !dma_ack_i && en_i) |=> dma_req_o);

  // R7
  assert_ovr_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R3
  assert_off_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !dma_req_o) |=> !dma_req_o);

  // R5
  assert_rise_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_req_o) |-> $past(en_i));

endmodule

bind cap_dma_bridge cap_dma_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .mode_i    (mode_i),
  .dma_ack_i (dma_ack_i),
  .dma_req_o (dma_req_o),
  .buf_o     (buf_o),
  .overrun_o (overrun_o)
);

// File: tb/cap_dma_bridge_tb_top.sv
module cap_dma_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic        sel = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        order = 1'b0;
  logic [1:0]  re = '0, fe = '0;
  logic [31:0] rv = '0, fv = '0;
  logic        ack = 1'b0;
  logic        req;
  logic [15:0] bufv;
  logic        ovr;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  logic        m_req;
  logic [15:0] m_buf;
  logic        m_ovr;

  always #10 clk = ~clk;

  cap_dma_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .chan_sel_i(sel), .mode_i(mode),
    .order_i(order), .rise_evt_i(re), .fall_evt_i(fe), .rise_val_i(rv),
    .fall_val_i(fv), .dma_ack_i(ack), .dma_req_o(req), .buf_o(bufv),
    .overrun_o(ovr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_buf = 0; m_ovr = 0;
    end else if (!en) begin
      m_req = 0;
    end else begin
      int  s;
      bit  r, f;
      s = sel ? 1 : 0;
      r = re[s] && mode[0];
      f = fe[s] && mode[1];
      if (m_req) begin
        if (r || f) m_ovr = 1;
        if (ack) m_req = 0;
      end else if (r || f) begin
        m_buf = (r && (!f || order)) ? rv[s*16 +: 16] : fv[s*16 +: 16];
        m_req = 1;
      end
    end
  end

  task automatic chk(string t, logic [17:0] act, logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act req=%0b buf=%h ovr=%0b exp req=%0b buf=%h ovr=%0b",
               t, act[17], act[16:1], act[0], exp[17], exp[16:1], exp[0]);
    end
  endtask

  // one clock with given strobes/ack; compares against model at the next negedge
  task automatic step(logic [1:0] r, logic [1:0] f, logic a);
    re = r; fe = f; ack = a;
    @(negedge clk);
    re = '0; fe = '0; ack = 0;
    chk(tag, {req, bufv, ovr}, {m_req, m_buf, m_ovr});
  endtask

  task automatic expect_out(string t, logic er, logic [15:0] eb, logic eo);
    chk(t, {req, bufv, ovr}, {er, eb, eo});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        done = 1; total++; bad++;
        $display("FAIL watchdog act=%0d exp<20000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 0, 16'h0000, 0);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 idle", 0, 16'h0000, 0);

    rv = {16'h2222, 16'h1111};
    fv = {16'h4444, 16'h3333};
    sel = 0; mode = 2'd1; tag = "R2";
    step(2'b10, 2'b00, 0); expect_out("R2 odd ignored", 0, 16'h0000, 0);
    tag = "R3";
    step(2'b00, 2'b01, 0); expect_out("R3 fall masked", 0, 16'h0000, 0);
    tag = "R5";
    step(2'b01, 2'b00, 0); expect_out("R5 load", 1, 16'h1111, 0);
    tag = "R6";
    step(2'b00, 2'b00, 0); expect_out("R6 held", 1, 16'h1111, 0);
    tag = "R8";
    step(2'b00, 2'b00, 1); expect_out("R8 ack drop", 0, 16'h1111, 0);

    sel = 1; mode = 2'd2; tag = "R3";
    step(2'b10, 2'b00, 0); expect_out("R3 rise masked", 0, 16'h1111, 0);
    tag = "R2";
    step(2'b00, 2'b10, 0); expect_out("R2 odd fall", 1, 16'h4444, 0);
    tag = "R8";
    step(2'b00, 2'b00, 1);
    step(2'b00, 2'b00, 1); expect_out("R8 idle ack", 0, 16'h4444, 0);

    mode = 2'd0; tag = "R3";
    step(2'b11, 2'b11, 0); expect_out("R3 off", 0, 16'h4444, 0);

    sel = 0; mode = 2'd3; order = 1; tag = "R4";
    rv = {16'h2222, 16'd11}; fv = {16'h4444, 16'd6};
    step(2'b01, 2'b01, 0); expect_out("R4 rise first", 1, 16'd11, 0);
    step(2'b00, 2'b00, 1);
    order = 0;
    step(2'b01, 2'b01, 0); expect_out("R4 fall first", 1, 16'd6, 0);

    tag = "R7"; rv[15:0] = 16'h00AA;
    step(2'b01, 2'b00, 0); expect_out("R7 drop", 1, 16'd6, 1);
    step(2'b00, 2'b01, 1); expect_out("R7 drop on ack", 0, 16'd6, 1);
    tag = "R8"; fv[15:0] = 16'h0BB0;
    step(2'b00, 2'b01, 0); expect_out("R8 rearm", 1, 16'h0BB0, 1);

    tag = "R9"; en = 0;
    step(2'b00, 2'b00, 0); expect_out("R9 req clr", 0, 16'h0BB0, 1);
    step(2'b01, 2'b01, 0); expect_out("R9 ignore", 0, 16'h0BB0, 1);
    en = 1;
    step(2'b00, 2'b00, 0); expect_out("R7 sticky", 0, 16'h0BB0, 1);

    tag = "R5";
    for (int i = 0; i < 2000; i++) begin
      sel = 1'($urandom); mode = 2'($urandom); order = 1'($urandom);
      en = ($urandom % 8) != 0;
      rv = $urandom; fv = $urandom;
      step(2'($urandom), 2'($urandom), ($urandom % 3) == 0);
    end

    rst_n = 0;
    #1;
    expect_out("R1 rereset", 0, 16'h0000, 0);
    @(negedge clk);
    rst_n = 1;

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule